// File: doc/BRIEF.md
# Clock-Inhibited Parallel-Load Shift Register

This block is an eight-stage register with a single serial output. Data enters it in one of two ways. It can be loaded broadside from eight parallel inputs, or it can be fed one bit at a time from a serial input while the chain shifts toward the output. A mode input selects the way. The register moves only when an active event occurs on a gated clock. That clock is built from two pins, a clock pin and an inhibit pin. An active event is a rise of their logical OR, so either pin can act as the clock while the other is held low. Holding either pin high freezes the register.

Both gating pins are sampled by a fast free-running system clock. The mode, serial and parallel inputs are sampled through a synchronizer of the same depth, so they stay aligned with the gating pins. An update is made in the system-clock cycle in which a rise of the synchronized OR is seen. An active-low clear empties the register at once and overrides every other input. Its release is synchronized, so leaving the cleared state cannot cause an update.

Top module: `pload_shift_reg`

## Requirements
- R1: While `clear_n_i` is low, all stages read zero and `ser_o` is 0. The register responds to the fall of `clear_n_i` without waiting for a system-clock edge. The clear overrides every other input.
- R2: With `shift_mode_i` = 1 (shift), each active event moves each stage one place toward the output. Stage 0 takes `ser_i`. `ser_o` is the last stage.
- R3: With `shift_mode_i` = 0 (load), an active event copies `par_i[i]` into stage i. So `par_i[WIDTH-1]` appears on `ser_o` first. Without an event, a change on `par_i` or on the mode has no effect on the register.
- R4: During a load, the value of `ser_i` has no effect on the captured word.
- R5: An active event is a 0-to-1 transition of (`gate_clk_i` OR `gate_inh_i`). With the inhibit held low, a rise of the clock pin advances the register exactly once, and a fall of the clock pin does not advance it. With the clock pin held low, the inhibit pin acts as the clock in the same way.
- R6: While either gating pin is held high, toggling the other pin causes no advance.
- R7: A rise of `gate_inh_i` while `gate_clk_i` is low counts as an active event and advances the register.
- R8: A pin transition that falls between two rising edges of `clk_i` shows its effect on `ser_o` after the third rising edge that follows it, and not before.
- R9: Releasing the clear never causes an update. This holds even if the gating pins rose while the clear was held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock that samples all pins |
| clear_n_i | input | 1 | Active-low clear, asynchronous assert, synchronized release |
| gate_clk_i | input | 1 | Clock pin of the gated-clock pair |
| gate_inh_i | input | 1 | Inhibit pin of the gated-clock pair |
| shift_mode_i | input | 1 | 1 = serial shift, 0 = broadside load |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Broadside data, bit i to stage i |
| ser_o | output | 1 | Serial output, the last stage |

## Verification
Only the last stage is visible at the port. A wrong stage value therefore shows up on `ser_o` only after enough further events have carried it to the end of the chain, which can take up to WIDTH-1 events. For this reason every check on the register's contents shifts the whole word out. A missing, doubled or spurious event also changes the bit position of everything that follows, so it causes a mismatch within the same shift-out. Latency faults are caught by sampling `ser_o` one cycle before and at the exact edge where the update must land.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int unsigned PSR_WIDTH_DEF = 8;
    localparam int unsigned PSR_SYNC_DEF  = 2;

    typedef enum logic {
        PSR_LOAD  = 1'b0,
        PSR_SHIFT = 1'b1
    } psr_mode_e;

    // Synchronized control pins travel together through one pipeline.
    typedef struct packed {
        logic      gclk;
        logic      ginh;
        psr_mode_e mode;
        logic      ser;
    } psr_pins_t;

    // Gated clock level: the complement of the NOR of the pair.
    function automatic logic psr_gate_level(input psr_pins_t p);
        return p.gclk | p.ginh;
    endfunction

endpackage

// File: rtl/psr_clear_sync.sv
module psr_clear_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic clear_n_i,
    output logic clear_act_o
);
    logic [STAGES-1:0] rel_q;

    always_ff @(posedge clk_i or negedge clear_n_i) begin
        if (!clear_n_i) begin
            rel_q <= '0;
        end else begin
            rel_q <= {rel_q[STAGES-2:0], 1'b1};
        end
    end

    assign clear_act_o = ~rel_q[STAGES-1];
endmodule

// File: rtl/psr_edge_gen.sv
module psr_edge_gen
    import psr_pkg::*;
#(
    parameter int unsigned WIDTH  = PSR_WIDTH_DEF,
    parameter int unsigned STAGES = PSR_SYNC_DEF
) (
    input  logic             clk_i,
    input  logic             clear_act_i,
    input  psr_pins_t        pins_i,
    input  logic [WIDTH-1:0] par_i,
    output psr_pins_t        pins_o,
    output logic [WIDTH-1:0] par_o,
    output logic             adv_o
);
    psr_pins_t        pins_pipe [STAGES];
    logic [WIDTH-1:0] par_pipe  [STAGES];
    logic             lvl_now;
    logic             lvl_q;

    always_ff @(posedge clk_i) begin
        pins_pipe[0] <= pins_i;
        par_pipe[0]  <= par_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_sync
        always_ff @(posedge clk_i) begin
            pins_pipe[s] <= pins_pipe[s-1];
            par_pipe[s]  <= par_pipe[s-1];
        end
    end

    assign pins_o  = pins_pipe[STAGES-1];
    assign par_o   = par_pipe[STAGES-1];
    assign lvl_now = psr_gate_level(pins_o);

    // Forced high during clear so the first cycle after release sees no rise.
    always_ff @(posedge clk_i or posedge clear_act_i) begin
        if (clear_act_i) begin
            lvl_q <= 1'b1;
        end else begin
            lvl_q <= lvl_now;
        end
    end

    assign adv_o = ~clear_act_i & ~lvl_q & lvl_now;
endmodule

// File: rtl/psr_stage_bank.sv
module psr_stage_bank
    import psr_pkg::*;
#(
    parameter int unsigned WIDTH = PSR_WIDTH_DEF
) (
    input  logic             clk_i,
    input  logic             clear_act_i,
    input  logic             adv_i,
    input  psr_mode_e        mode_i,
    input  logic             ser_i,
    input  logic [WIDTH-1:0] par_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic shift_src;
        logic d;
        logic q;

        if (i == 0) begin : g_head
            assign shift_src = ser_i;
        end else begin : g_body
            assign shift_src = q_o[i-1];
        end

        assign d = (mode_i == PSR_SHIFT) ? shift_src : par_i[i];

        always_ff @(posedge clk_i or posedge clear_act_i) begin
            if (clear_act_i) begin
                q <= 1'b0;
            end else if (adv_i) begin
                q <= d;
            end
        end

        assign q_o[i] = q;
    end
endmodule

// File: rtl/pload_shift_reg.sv
module pload_shift_reg
    import psr_pkg::*;
#(
    parameter int unsigned WIDTH       = PSR_WIDTH_DEF,
    parameter int unsigned SYNC_STAGES = PSR_SYNC_DEF
) (
    input  logic             clk_i,
    input  logic             clear_n_i,
    input  logic             gate_clk_i,
    input  logic             gate_inh_i,
    input  logic             shift_mode_i,
    input  logic             ser_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             ser_o
);
    localparam int unsigned LAST = WIDTH - 1;

    psr_pins_t        pins_raw;
    psr_pins_t        pins_s;
    logic [WIDTH-1:0] par_s;
    logic             clear_act;
    logic             adv;
    logic [WIDTH-1:0] stage_q;

    assign pins_raw.gclk = gate_clk_i;
    assign pins_raw.ginh = gate_inh_i;
    assign pins_raw.mode = psr_mode_e'(shift_mode_i);
    assign pins_raw.ser  = ser_i;

    psr_clear_sync #(.STAGES(SYNC_STAGES)) clr_i (
        .clk_i      (clk_i),
        .clear_n_i  (clear_n_i),
        .clear_act_o(clear_act)
    );

    psr_edge_gen #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) edge_i (
        .clk_i      (clk_i),
        .clear_act_i(clear_act),
        .pins_i     (pins_raw),
        .par_i      (par_i),
        .pins_o     (pins_s),
        .par_o      (par_s),
        .adv_o      (adv)
    );

    psr_stage_bank #(.WIDTH(WIDTH)) bank_i (
        .clk_i      (clk_i),
        .clear_act_i(clear_act),
        .adv_i      (adv),
        .mode_i     (pins_s.mode),
        .ser_i      (pins_s.ser),
        .par_i      (par_s),
        .q_o        (stage_q)
    );

    assign ser_o = stage_q[LAST];
endmodule

// File: rtl/psr_checker.sv
module psr_checker
    import psr_pkg::*;
#(
    parameter int unsigned WIDTH = PSR_WIDTH_DEF
) (
    input logic             clk_i,
    input logic             clear_n_i,
    input logic             clear_act_i,
    input logic             adv_i,
    input psr_pins_t        pins_i,
    input logic [WIDTH-1:0] par_i,
    input logic [WIDTH-1:0] q_i,
    input logic             ser_o_i
);
    // R1: a low clear pin means an empty register at every edge.
    assert_clear_empties_R1: assert property (@(posedge clk_i)
        !clear_n_i |-> (q_i == '0 && !ser_o_i));

    // R2: a shift event moves the chain one place and takes in the serial bit.
    assert_shift_step_R2: assert property (@(posedge clk_i) disable iff (clear_act_i)
        (adv_i && pins_i.mode == PSR_SHIFT) |=>
            (q_i == {$past(q_i[WIDTH-2:0]), $past(pins_i.ser)}));

    // R3 / R4: a load event captures the parallel word only.
    assert_load_word_R3: assert property (@(posedge clk_i) disable iff (clear_act_i)
        (adv_i && pins_i.mode == PSR_LOAD) |=> (q_i == $past(par_i)));

    // R6: no event, no change.
    assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (clear_act_i)
        !adv_i |=> $stable(q_i));

    // R5: one rise yields one event, never two in a row.
    assert_single_event_R5: assert property (@(posedge clk_i) disable iff (clear_act_i)
        adv_i |=> !adv_i);
endmodule

bind pload_shift_reg psr_checker #(.WIDTH(WIDTH)) chk_i (
    .clk_i      (clk_i),
    .clear_n_i  (clear_n_i),
    .clear_act_i(clear_act),
    .adv_i      (adv),
    .pins_i     (pins_s),
    .par_i      (par_s),
    .q_i        (stage_q),
    .ser_o_i    (ser_o)
);

// File: tb/pload_shift_reg_tb_top.sv
`timescale 1ns/1ps
module pload_shift_reg_tb_top;
    localparam int W = 8;

    logic         clk_i = 1'b0;
    logic         clear_n_i = 1'b0;
    logic         gate_clk_i = 1'b0;
    logic         gate_inh_i = 1'b0;
    logic         shift_mode_i = 1'b1;
    logic         ser_i = 1'b0;
    logic [W-1:0] par_i = '0;
    logic         ser_o;

    int n_run  = 0;
    int n_fail = 0;
    logic [W-1:0] model = '0;

    always #5 clk_i = ~clk_i;

    pload_shift_reg #(.WIDTH(W)) dut_i (
        .clk_i       (clk_i),
        .clear_n_i   (clear_n_i),
        .gate_clk_i  (gate_clk_i),
        .gate_inh_i  (gate_inh_i),
        .shift_mode_i(shift_mode_i),
        .ser_i       (ser_i),
        .par_i       (par_i),
        .ser_o       (ser_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ser_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    // One active event through the chosen pin, then back to idle (low/low).
    task automatic pulse(input bit via_inh);
        if (via_inh) gate_inh_i = 1'b1; else gate_clk_i = 1'b1;
        cyc(4);
        if (via_inh) gate_inh_i = 1'b0; else gate_clk_i = 1'b0;
        cyc(4);
    endtask

    // Apply the expected effect of one event to the bench model.
    function automatic logic [W-1:0] step(input logic [W-1:0] m, input logic mode,
                                          input logic s, input logic [W-1:0] p);
        return mode ? ((m << 1) | W'(s)) : p;
    endfunction

    // Shift the whole model word out and compare each bit (zeros shifted in).
    task automatic drain(input string req);
        shift_mode_i = 1'b1;
        ser_i = 1'b0;
        for (int k = 0; k < W; k++) begin
            check(req, ser_o, model[W-1]);
            if (k < W - 1) begin
                pulse(k[0]);
                model = step(model, 1'b1, 1'b0, '0);
            end
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state while the clear is held.
        cyc(5);
        check("R1 reset state", ser_o, 1'b0);
        clear_n_i = 1'b1;
        cyc(4);
        check("R9 no update on release", ser_o, 1'b0);

        // R8: load all ones; visible only after the third rising edge.
        shift_mode_i = 1'b0;
        par_i = '1;
        gate_clk_i = 1'b1;
        cyc(2);
        check("R8 not yet at second edge", ser_o, 1'b0);
        cyc(1);
        check("R8 visible at third edge", ser_o, 1'b1);
        model = '1;
        gate_clk_i = 1'b0;
        cyc(4);
        check("R5 falling clock pin no advance", ser_o, 1'b1);

        // R3: no event, parallel change ignored.
        par_i = '0;
        cyc(10);
        check("R3 load waits for event", ser_o, 1'b1);
        drain("R2 shift out after load");

        // R2 R3 R4 R5 R7: every parallel word, alternating the clocking pin.
        for (int v = 0; v < (1 << W); v++) begin
            shift_mode_i = 1'b0;
            par_i = W'(v);
            ser_i = ~par_i[0];
            pulse(v[0]);
            model = step(model, 1'b0, ser_i, par_i);
            check(v[0] ? "R7 inhibit as clock load" : "R3 load via clock pin",
                  ser_o, model[W-1]);
            shift_mode_i = 1'b1;
            for (int k = 0; k < W - 1; k++) begin
                ser_i = v[k] ^ k[0];
                pulse(k[0] ^ v[1]);
                model = step(model, 1'b1, ser_i, '0);
                check("R2 serial shift", ser_o, model[W-1]);
            end
        end
        drain("R4 serial input ignored on load");

        // R6: clock pin held high (its rise is one event), inhibit toggling blocked.
        shift_mode_i = 1'b0;
        par_i = 8'hB4;
        gate_clk_i = 1'b1;
        cyc(4);
        model = 8'hB4;
        shift_mode_i = 1'b1;
        ser_i = 1'b1;
        for (int t = 0; t < 6; t++) begin
            gate_inh_i = ~gate_inh_i;
            cyc(4);
        end
        gate_inh_i = 1'b0;
        cyc(4);
        gate_clk_i = 1'b0;
        cyc(4);
        drain("R6 clock high blocks inhibit");

        // R6: inhibit held high, clock pin toggling blocked.
        shift_mode_i = 1'b0;
        par_i = 8'h6D;
        gate_inh_i = 1'b1;
        cyc(4);
        model = 8'h6D;
        shift_mode_i = 1'b1;
        for (int t = 0; t < 6; t++) begin
            gate_clk_i = ~gate_clk_i;
            cyc(4);
        end
        gate_inh_i = 1'b0;
        cyc(4);
        drain("R6 inhibit high blocks clock");

        // R1: asynchronous clear mid-operation.
        shift_mode_i = 1'b0;
        par_i = '1;
        pulse(1'b0);
        check("R3 load before clear", ser_o, 1'b1);
        @(posedge clk_i);
        #2;
        clear_n_i = 1'b0;
        #1;
        check("R1 clear without clock edge", ser_o, 1'b0);
        // R9: gating rises during clear, then release: nothing is loaded.
        gate_clk_i = 1'b1;
        cyc(6);
        clear_n_i = 1'b1;
        cyc(8);
        check("R9 release no spurious load", ser_o, 1'b0);
        gate_clk_i = 1'b0;
        cyc(4);
        model = '0;
        drain("R9 register empty after release");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule